// File: doc/BRIEF.md
# Segment Table Address Translation Unit

This block turns a two-part logical address (a segment number and an offset inside that segment) into a physical address. It keeps a small table of segment descriptors in registers. Each descriptor holds a physical base address, a segment length, a valid flag and three permission bits: read, write and execute. It also keeps a length register that gives how many table entries are currently in use. A configuration port writes single descriptors and the length register.

A request carries a segment number, an offset and an access type. One clock later the unit answers with either a physical address (base plus offset) or a trap code. The checks run in a fixed priority, highest first:

1. Segment number against the length register.
2. The entry's valid flag.
3. The offset against the segment length.
4. The access type against the entry's permissions.

The first check that fails decides the code. A faulting answer drives the physical address to zero and raises a fault strobe for that one cycle. Fetching descriptors from memory and choosing where segments are placed are left to surrounding logic.

Top module: `seg_xlate`

## Requirements
- R1: After reset the response outputs are all zero, the length register is 0 and every table entry is invalid, so the first request after reset traps with code 1.
- R2: A response appears exactly one cycle after a request: rspValid is high in the cycle after reqValid was sampled, and low after a cycle with no request.
- R3: A segment number greater than or equal to the length register traps with code 1, whatever the entry holds.
- R4: A segment whose entry has its valid flag clear traps with code 2.
- R5: An offset greater than or equal to the entry's length traps with code 3. An offset of length minus one is accepted, and a length of zero rejects every offset.
- R6: The access type is encoded as 0 = read, 1 = write, 2 = execute, 3 = reserved. It is checked against the permission bits: bit 0 = read, bit 1 = write, bit 2 = execute. An access whose bit is clear, and every reserved access, traps with code 4.
- R7: When several checks fail, the reported code follows this priority: range (1), then invalid (2), then bound (3), then permission (4).
- R8: A request that passes every check returns code 0, no fault, and a physical address equal to base plus offset, truncated to PA_W bits.
- R9: On a trap, rspPhys is zero and rspFault is high together with a nonzero code for that response cycle only.
- R10: A descriptor or length write sampled in cycle t affects requests sampled from cycle t+1 onward. A request sampled in the same cycle as the write still sees the old contents.
- R11: A length value above SEG_COUNT is stored as SEG_COUNT, so segment numbers that have no table slot always trap with code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for one table descriptor |
| cfgSeg | input | SEG_W | Descriptor index to write |
| cfgBase | input | PA_W | Physical base address of the segment |
| cfgLimit | input | OFF_W+1 | Segment length in address units |
| cfgValid | input | 1 | Valid flag for the descriptor |
| cfgPerm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| lenWe | input | 1 | Write strobe for the table length register |
| lenValue | input | SEG_W+1 | New table length (capped at SEG_COUNT) |
| reqValid | input | 1 | Translation request present |
| reqSeg | input | SEG_W | Segment number of the request |
| reqOffset | input | OFF_W | Offset within the segment |
| reqAccess | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rspValid | output | 1 | Response present (one cycle after a request) |
| rspFault | output | 1 | Trap strobe for this response |
| rspCode | output | 3 | 0 ok, 1 range, 2 invalid, 3 bound, 4 permission |
| rspPhys | output | PA_W | Translated physical address, zero on a trap |

## Verification
The bench builds the unit with SEG_COUNT = 6, OFF_W = 8 and PA_W = 12. Six slots addressed by a three-bit segment number leave segments 6 and 7 with no slot at all, which brings the length cap and the out-of-range trap for slot-less numbers within reach. The 12-bit physical width lets a base near the top of the space wrap when the offset is added. The 8-bit offset with a 9-bit length allows a segment of full span, so the accepted-offset edge at 255 can be exercised next to a zero-length segment.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [2:0] {
    TRAP_NONE      = 3'd0,
    TRAP_SEG_RANGE = 3'd1,
    TRAP_INVALID   = 3'd2,
    TRAP_BOUND     = 3'd3,
    TRAP_PERM      = 3'd4
  } trap_e;

  // Permission bits, bit 0 read, bit 1 write, bit 2 execute
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  // Strobes from the check logic to the datapath
  typedef struct packed {
    logic  issue;
    logic  trap;
    trap_e code;
  } ctl_strobe_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [1:0]       reqAccess,
  input  logic [LEN_W-1:0] lenReg,
  input  logic             entValid,
  input  logic [OFF_W:0]   entLimit,
  input  logic [2:0]       entPerm,
  output ctl_strobe_t      strobe
);

  access_e accType;
  perm_t   permBits;
  logic    segInRange;
  logic    offInBound;
  logic    permGranted;
  trap_e   trapCode;

  assign accType  = access_e'(reqAccess);
  assign permBits = perm_t'(entPerm);

  always_comb begin
    segInRange = LEN_W'(reqSeg) < lenReg;
    offInBound = {1'b0, reqOffset} < entLimit;
    unique case (accType)
      ACC_READ:  permGranted = permBits.r;
      ACC_WRITE: permGranted = permBits.w;
      ACC_EXEC:  permGranted = permBits.x;
      default:   permGranted = 1'b0;
    endcase
  end

  // Fixed priority: range, valid flag, bound, permission
  always_comb begin
    if (!segInRange)       trapCode = TRAP_SEG_RANGE;
    else if (!entValid)    trapCode = TRAP_INVALID;
    else if (!offInBound)  trapCode = TRAP_BOUND;
    else if (!permGranted) trapCode = TRAP_PERM;
    else                   trapCode = TRAP_NONE;
  end

  always_comb begin
    strobe.issue = reqValid;
    strobe.trap  = reqValid && (trapCode != TRAP_NONE);
    strobe.code  = trapCode;
  end

  // R9
  trap_needs_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trap |-> strobe.issue);

  // R5
  pass_within_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !strobe.trap) |-> ({1'b0, reqOffset} < entLimit) && entValid);

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int SEG_W     = 3,
  parameter int OFF_W     = 12,
  parameter int PA_W      = 20,
  parameter int LEN_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEG_W-1:0] cfgSeg,
  input  logic [PA_W-1:0]  cfgBase,
  input  logic [OFF_W:0]   cfgLimit,
  input  logic             cfgValid,
  input  logic [2:0]       cfgPerm,
  input  logic             lenWe,
  input  logic [LEN_W-1:0] lenValue,
  input  logic             reqValid,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOffset,
  input  ctl_strobe_t      strobe,
  output logic [LEN_W-1:0] lenReg,
  output logic             entValid,
  output logic [OFF_W:0]   entLimit,
  output logic [2:0]       entPerm,
  output logic             rspValid,
  output logic             rspFault,
  output logic [2:0]       rspCode,
  output logic [PA_W-1:0]  rspPhys
);

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(SEG_COUNT);

  logic [PA_W-1:0]  baseTab  [SEG_COUNT];
  logic [OFF_W:0]   limitTab [SEG_COUNT];
  logic             validTab [SEG_COUNT];
  logic [2:0]       permTab  [SEG_COUNT];

  logic [PA_W-1:0]  baseSel;
  logic [PA_W-1:0]  physSum;

  // Descriptor slots
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseTab[g]  <= '0;
        limitTab[g] <= '0;
        validTab[g] <= 1'b0;
        permTab[g]  <= '0;
      end else if (cfgWe && (cfgSeg == SEG_W'(g))) begin
        baseTab[g]  <= cfgBase;
        limitTab[g] <= cfgLimit;
        validTab[g] <= cfgValid;
        permTab[g]  <= cfgPerm;
      end
    end
  end

  // Length register, capped at the slot count
  always_ff @(posedge clk) begin
    if (!rstN)       lenReg <= '0;
    else if (lenWe)  lenReg <= (lenValue > LEN_CAP) ? LEN_CAP : lenValue;
  end

  // Descriptor lookup; numbers without a slot read as empty
  always_comb begin
    baseSel  = '0;
    entLimit = '0;
    entValid = 1'b0;
    entPerm  = '0;
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (reqSeg == SEG_W'(i)) begin
        baseSel  = baseTab[i];
        entLimit = limitTab[i];
        entValid = validTab[i];
        entPerm  = permTab[i];
      end
    end
  end

  assign physSum = baseSel + PA_W'(reqOffset);

  // Response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspCode  <= '0;
      rspPhys  <= '0;
    end else begin
      rspValid <= strobe.issue;
      rspFault <= strobe.trap;
      rspCode  <= strobe.issue ? 3'(strobe.code) : 3'(TRAP_NONE);
      rspPhys  <= (strobe.issue && !strobe.trap) ? physSum : '0;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R9
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPhys == '0) && (rspCode != 3'd0) && rspValid);

  // R11
  len_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenReg <= LEN_CAP);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int OFF_W     = 12,
  parameter int PA_W      = 20,
  localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
  localparam int LEN_W    = SEG_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEG_W-1:0] cfgSeg,
  input  logic [PA_W-1:0]  cfgBase,
  input  logic [OFF_W:0]   cfgLimit,
  input  logic             cfgValid,
  input  logic [2:0]       cfgPerm,
  input  logic             lenWe,
  input  logic [LEN_W-1:0] lenValue,
  input  logic             reqValid,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [1:0]       reqAccess,
  output logic             rspValid,
  output logic             rspFault,
  output logic [2:0]       rspCode,
  output logic [PA_W-1:0]  rspPhys
);

  ctl_strobe_t      strobe;
  logic [LEN_W-1:0] lenReg;
  logic             entValid;
  logic [OFF_W:0]   entLimit;
  logic [2:0]       entPerm;

  seg_xlate_ctrl #(.SEG_W(SEG_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqOffset(reqOffset), .reqAccess(reqAccess),
    .lenReg(lenReg), .entValid(entValid), .entLimit(entLimit), .entPerm(entPerm),
    .strobe(strobe)
  );

  seg_xlate_dp #(.SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W),
                 .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSeg(cfgSeg), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
    .cfgValid(cfgValid), .cfgPerm(cfgPerm),
    .lenWe(lenWe), .lenValue(lenValue),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqOffset(reqOffset),
    .strobe(strobe),
    .lenReg(lenReg), .entValid(entValid), .entLimit(entLimit), .entPerm(entPerm),
    .rspValid(rspValid), .rspFault(rspFault), .rspCode(rspCode), .rspPhys(rspPhys)
  );

endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;

  localparam int SEG_COUNT = 6;
  localparam int OFF_W     = 8;
  localparam int PA_W      = 12;
  localparam int NVEC      = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgSeg = '0;
  logic [PA_W-1:0] cfgBase = '0;
  logic [OFF_W:0] cfgLimit = '0;
  logic cfgValid = 1'b0;
  logic [2:0] cfgPerm = '0;
  logic lenWe = 1'b0;
  logic [3:0] lenValue = '0;
  logic reqValid = 1'b0;
  logic [2:0] reqSeg = '0;
  logic [OFF_W-1:0] reqOffset = '0;
  logic [1:0] reqAccess = '0;
  logic rspValid, rspFault;
  logic [2:0] rspCode;
  logic [PA_W-1:0] rspPhys;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_xlate #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSeg(cfgSeg), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
    .cfgValid(cfgValid), .cfgPerm(cfgPerm), .lenWe(lenWe), .lenValue(lenValue),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqOffset(reqOffset), .reqAccess(reqAccess),
    .rspValid(rspValid), .rspFault(rspFault), .rspCode(rspCode), .rspPhys(rspPhys)
  );

  // Vector fields: {seg[3], offset[8], access[2], expected code[3], expected phys[12]}
  localparam logic [27:0] VEC [NVEC] = '{
    {3'd0, 8'h10, 2'd0, 3'd0, 12'h110},  // read inside segment 0
    {3'd0, 8'h3F, 2'd2, 3'd0, 12'h13F},  // last offset, execute
    {3'd0, 8'h40, 2'd0, 3'd3, 12'h000},  // offset equals length
    {3'd0, 8'h05, 2'd1, 3'd4, 12'h000},  // write not allowed
    {3'd0, 8'h05, 2'd3, 3'd4, 12'h000},  // reserved access
    {3'd1, 8'hFF, 2'd1, 3'd0, 12'h2FF},  // full-span segment edge
    {3'd1, 8'h00, 2'd2, 3'd4, 12'h000},  // execute not allowed
    {3'd2, 8'h15, 2'd2, 3'd0, 12'h005},  // base plus offset wraps
    {3'd3, 8'h00, 2'd0, 3'd2, 12'h000},  // invalid entry
    {3'd3, 8'h50, 2'd1, 3'd2, 12'h000},  // R7: invalid beats bound
    {3'd4, 8'h00, 2'd0, 3'd3, 12'h000},  // zero-length segment
    {3'd5, 8'h00, 2'd0, 3'd1, 12'h000},  // R7: range beats all, len 5
    {3'd7, 8'h00, 2'd0, 3'd1, 12'h000},  // number with no slot
    {3'd0, 8'h40, 2'd1, 3'd3, 12'h000}   // R7: bound beats permission
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [2:0] code);
    case (code)
      3'd0: return "R8";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a negedge; returns at the negedge after the response edge
  task automatic doReq(input logic [2:0] seg, input logic [OFF_W-1:0] off, input logic [1:0] acc);
    reqValid = 1'b1; reqSeg = seg; reqOffset = off; reqAccess = acc;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic [2:0] code, input logic [PA_W-1:0] phys);
    check({tag, " valid"}, 32'(rspValid), 32'd1);
    check({tag, " code"},  32'(rspCode),  32'(code));
    check({tag, " fault"}, 32'(rspFault), 32'(code != 3'd0));
    check({tag, " phys"},  32'(rspPhys),  32'(phys));
  endtask

  task automatic writeDesc(input logic [2:0] seg, input logic [PA_W-1:0] base,
                           input logic [OFF_W:0] lim, input logic vld, input logic [2:0] perm);
    cfgWe = 1'b1; cfgSeg = seg; cfgBase = base; cfgLimit = lim; cfgValid = vld; cfgPerm = perm;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic writeLen(input logic [3:0] val);
    lenWe = 1'b1; lenValue = val;
    @(negedge clk);
    lenWe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rspValid", 32'(rspValid), 32'd0);
    check("R1 rspFault", 32'(rspFault), 32'd0);
    check("R1 rspCode",  32'(rspCode),  32'd0);
    check("R1 rspPhys",  32'(rspPhys),  32'd0);
    rstN = 1'b1;
    @(negedge clk);
    doReq(3'd0, 8'h00, 2'd0);
    expectRsp("R1 length zero after reset", 3'd1, '0);

    writeDesc(3'd0, 12'h100, 9'h040, 1'b1, 3'b101);
    writeDesc(3'd1, 12'h200, 9'h100, 1'b1, 3'b011);
    writeDesc(3'd2, 12'hFF0, 9'h020, 1'b1, 3'b111);
    writeDesc(3'd3, 12'h300, 9'h010, 1'b0, 3'b111);
    writeDesc(3'd4, 12'h400, 9'h000, 1'b1, 3'b111);
    writeDesc(3'd5, 12'h500, 9'h008, 1'b1, 3'b000);
    writeLen(4'd5);

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VEC[i];
      doReq(v[27:25], v[24:17], v[16:15]);
      expectRsp($sformatf("%s vector %0d", tagFor(v[14:12]), i), v[14:12], v[11:0]);
    end

    // R2 and R9: no response and no fault in the cycle after a faulting one
    doReq(3'd3, 8'h00, 2'd0);
    check("R9 fault on trap", 32'(rspFault), 32'd1);
    @(negedge clk);
    check("R2 idle rspValid", 32'(rspValid), 32'd0);
    check("R9 fault single cycle", 32'(rspFault), 32'd0);

    // R11: length above the slot count is capped
    writeLen(4'd15);
    doReq(3'd5, 8'h00, 2'd0);
    expectRsp("R11 segment 5 now in range", 3'd4, '0);
    doReq(3'd6, 8'h00, 2'd0);
    expectRsp("R11 segment 6 has no slot", 3'd1, '0);

    // R10: descriptor write in the same cycle as a request
    cfgWe = 1'b1; cfgSeg = 3'd3; cfgBase = 12'h300; cfgLimit = 9'h010;
    cfgValid = 1'b1; cfgPerm = 3'b111;
    reqValid = 1'b1; reqSeg = 3'd3; reqOffset = 8'h02; reqAccess = 2'd0;
    @(negedge clk);
    cfgWe = 1'b0; reqValid = 1'b0;
    expectRsp("R10 same-cycle sees old entry", 3'd2, '0);
    doReq(3'd3, 8'h02, 2'd0);
    expectRsp("R10 next cycle sees new entry", 3'd0, 12'h302);

    // R10: length write in the same cycle as a request
    lenWe = 1'b1; lenValue = 4'd2;
    reqValid = 1'b1; reqSeg = 3'd3; reqOffset = 8'h03; reqAccess = 2'd1;
    @(negedge clk);
    lenWe = 1'b0; reqValid = 1'b0;
    expectRsp("R10 same-cycle sees old length", 3'd0, 12'h303);
    doReq(3'd3, 8'h03, 2'd1);
    expectRsp("R10 R3 new length applies", 3'd1, '0);

    // R6: execute allowed only where bit 2 is set
    doReq(3'd0, 8'h01, 2'd2);
    expectRsp("R6 execute granted", 3'd0, 12'h101);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule